// File: doc/BRIEF.md
# Scalar/Vector Memory Sync Stall Unit

This block keeps memory ordering inside one instruction stream when a scalar core and a vector unit reach memory over separate, decoupled paths. It keeps a count of the memory instructions each unit has issued but not yet committed. When a typed sync instruction is decoded, the block holds the fetch stage until the older memory instructions of the class that the sync names have all committed. Memory instructions issued after the sync do not lengthen the wait.

A sync of kind "X after Y" makes every class-Y memory operation older than the sync appear to complete before any class-X memory operation younger than it. One sync covers read-after-write, write-after-read and write-after-write ordering together. Ordering among scalar operations needs no sync. Vector-after-vector and per-element (virtual processor) syncs cost nothing, because there is a single vector memory path and no vector cache. A scalar-after-vector drain can last thousands of cycles, so the hold has no time limit. The block also keeps a saturating count of the cycles spent holding fetch, and a sticky flag for commit pulses that arrive with nothing in flight.

Commits within each unit are taken to arrive in issue order, so the older operations of a sync are the first ones to commit after it.

Top module: `memsync_stall_unit`

## Requirements
- R1: `sync_kind` is decoded as follows. 2'b00 is scalar-after-vector and waits on the vector memory operations that are in flight when the request is accepted. 2'b01 is vector-after-scalar and waits on the scalar ones in flight at that point.
- R2: Kinds 2'b10 (vector after vector) and 2'b11 (element after element) raise `sync_done` in the cycle of the accepted request and never raise `fetch_hold`, whatever the in-flight counts are.
- R3: If the watched unit has nothing in flight when a 2'b00 or 2'b01 request is accepted, `sync_done` is high in that same cycle and `fetch_hold` stays low.
- R4: Otherwise `fetch_hold` rises in the cycle after the request and stays high with no time limit. `sync_done` goes high in the first cycle in which none of the older watched operations is still uncommitted, and `fetch_hold` falls in the cycle after that. A commit in the request cycle counts toward the drain.
- R5: Watched-unit operations issued in the request cycle or later do not extend the hold.
- R6: A `sync_req` that arrives while a sync is pending (`fetch_hold` high) is ignored: it produces no `sync_done` and starts no new hold.
- R7: An issue pulse and a commit pulse from the same unit in the same cycle leave that unit's in-flight count unchanged.
- R8: A commit pulse while the unit's count is zero, with no issue from that unit in the same cycle, sets `mem_err` from the next cycle until reset. The count stays at zero.
- R9: `stall_cycles` adds one for each cycle in which `fetch_hold` is high. The new value is visible in the following cycle, and the count saturates at all ones.
- R10: After synchronous reset, `fetch_hold`, `sync_done` and `mem_err` are 0, `stall_cycles` is 0, and both in-flight counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | A sync instruction is decoded this cycle |
| sync_kind | input | 2 | Sync kind: 00 scalar-after-vector, 01 vector-after-scalar, 10 vector-after-vector, 11 element-after-element |
| sc_issue | input | 1 | Scalar memory instruction issued |
| sc_commit | input | 1 | Scalar memory instruction committed |
| vec_issue | input | 1 | Vector memory instruction issued |
| vec_commit | input | 1 | Vector memory instruction committed |
| fetch_hold | output | 1 | Hold the fetch stage (registered) |
| sync_done | output | 1 | Pulse: the current sync is satisfied |
| mem_err | output | 1 | Sticky: commit seen with nothing in flight |
| stall_cycles | output | STALL_W | Saturating count of cycles with fetch held |

## Verification
The assertions check on every cycle the cycle-level rules. Free kinds finish in their request cycle. The hold continues until `sync_done` and falls one cycle after it. The drain count drops by exactly one per watched commit. An issue and a commit together leave a count unchanged. The error flag is sticky, and the stall counter steps or holds. Only the bench scenarios can show that the wait lasts exactly as long as the older operations: that younger issues add no cycles, that a request during a hold is dropped, that an underflow leaves the count at zero, that a drain of hundreds of cycles has no timeout, and that the cycle total saturates.

// File: rtl/memsync_pkg.sv
package memsync_pkg;
  typedef enum logic [1:0] {
    KIND_SCALAR_AFTER_VEC = 2'b00,
    KIND_VEC_AFTER_SCALAR = 2'b01,
    KIND_VEC_AFTER_VEC    = 2'b10,
    KIND_ELEM_AFTER_ELEM  = 2'b11
  } sync_kind_e;

  localparam int UNIT_SCALAR = 0;
  localparam int UNIT_VECTOR = 1;
  localparam int NUM_UNITS   = 2;
endpackage

// File: rtl/mem_inflight_ctr.sv
module mem_inflight_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (issue_i && !commit_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (commit_i && !issue_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o     = cnt_q;
  assign underflow_o = commit_i && !issue_i && (cnt_q == '0);

  // R7
  issue_commit_same_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_i && commit_i) |=> $stable(cnt_q));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !issue_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sync_drain_tracker.sv
module sync_drain_tracker #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             watch_vec_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             sc_commit_i,
  input  logic             vec_commit_i,
  output logic             pending_o,
  output logic             done_o
);
  logic             pending_q;
  logic             watch_vec_q;
  logic [CNT_W-1:0] left_q;
  logic             commit_w;

  assign commit_w = watch_vec_q ? vec_commit_i : sc_commit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= 1'b0;
      watch_vec_q <= 1'b0;
      left_q      <= '0;
    end else if (start_i) begin
      pending_q   <= 1'b1;
      watch_vec_q <= watch_vec_i;
      left_q      <= load_i;
    end else if (pending_q) begin
      if (left_q == '0) begin
        pending_q <= 1'b0;
      end else if (commit_w) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign pending_o = pending_q;
  assign done_o    = pending_q && (left_q == '0);

  // R4
  drain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pending_q && left_q != '0 && commit_w) |=> (left_q == $past(left_q) - 1'b1));

  // R4
  drain_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !pending_q);
endmodule

// File: rtl/stall_cycle_ctr.sv
module stall_cycle_ctr #(
  parameter int STALL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_i,
  output logic [STALL_W-1:0] cycles_o
);
  localparam logic [STALL_W-1:0] SAT_VAL = '1;

  logic [STALL_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
    end else if (hold_i && cyc_q != SAT_VAL) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign cycles_o = cyc_q;

  // R9
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i && cyc_q != SAT_VAL) |=> (cyc_q == $past(cyc_q) + 1'b1));

  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_i || cyc_q == SAT_VAL) |=> $stable(cyc_q));
endmodule

// File: rtl/memsync_stall_unit.sv
module memsync_stall_unit
  import memsync_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int STALL_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_req,
  input  logic [1:0]         sync_kind,
  input  logic               sc_issue,
  input  logic               sc_commit,
  input  logic               vec_issue,
  input  logic               vec_commit,
  output logic               fetch_hold,
  output logic               sync_done,
  output logic               mem_err,
  output logic [STALL_W-1:0] stall_cycles
);
  logic [NUM_UNITS-1:0] issue_w;
  logic [NUM_UNITS-1:0] commit_w;
  logic [NUM_UNITS-1:0] underflow_w;
  logic [CNT_W-1:0]     count_w [NUM_UNITS];

  assign issue_w[UNIT_SCALAR]  = sc_issue;
  assign issue_w[UNIT_VECTOR]  = vec_issue;
  assign commit_w[UNIT_SCALAR] = sc_commit;
  assign commit_w[UNIT_VECTOR] = vec_commit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    mem_inflight_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk        (clk),
      .rst        (rst),
      .issue_i    (issue_w[u]),
      .commit_i   (commit_w[u]),
      .count_o    (count_w[u]),
      .underflow_o(underflow_w[u])
    );
  end

  sync_kind_e       kind;
  logic             pending;
  logic             drain_done;
  logic             accept;
  logic             free_kind;
  logic             watch_vec;
  logic [CNT_W-1:0] watched_cnt;
  logic             watched_commit;
  logic             needs_wait;
  logic             instant_done;
  logic [CNT_W-1:0] load_val;
  logic             err_q;

  always_comb begin
    kind           = sync_kind_e'(sync_kind);
    accept         = sync_req && !pending;
    free_kind      = (kind == KIND_VEC_AFTER_VEC) || (kind == KIND_ELEM_AFTER_ELEM);
    watch_vec      = (kind == KIND_SCALAR_AFTER_VEC);
    watched_cnt    = watch_vec ? count_w[UNIT_VECTOR] : count_w[UNIT_SCALAR];
    watched_commit = watch_vec ? vec_commit : sc_commit;
    needs_wait     = accept && !free_kind && (watched_cnt != '0);
    instant_done   = accept && !needs_wait;
    load_val       = watched_cnt - {{(CNT_W-1){1'b0}}, watched_commit};
  end

  sync_drain_tracker #(.CNT_W(CNT_W)) i_drain (
    .clk         (clk),
    .rst         (rst),
    .start_i     (needs_wait),
    .watch_vec_i (watch_vec),
    .load_i      (load_val),
    .sc_commit_i (sc_commit),
    .vec_commit_i(vec_commit),
    .pending_o   (pending),
    .done_o      (drain_done)
  );

  stall_cycle_ctr #(.STALL_W(STALL_W)) i_stall (
    .clk     (clk),
    .rst     (rst),
    .hold_i  (pending),
    .cycles_o(stall_cycles)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (|underflow_w) begin
      err_q <= 1'b1;
    end
  end

  assign fetch_hold = pending;
  assign sync_done  = instant_done || drain_done;
  assign mem_err    = err_q;

  // R2
  free_kind_done_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_req && !fetch_hold && sync_kind[1]) |-> (sync_done ##1 !fetch_hold));

  // R3
  idle_unit_done_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_req && !fetch_hold && !sync_kind[1] && watched_cnt == '0) |-> sync_done);

  // R4
  hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_hold && !sync_done) |=> fetch_hold);

  // R4
  release_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_hold && sync_done) |=> !fetch_hold);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    mem_err |=> mem_err);
endmodule

// File: tb/test_memsync_stall_unit.sv
module test_memsync_stall_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_req = 1'b0;
  logic [1:0]  sync_kind = 2'b00;
  logic        sc_issue = 1'b0, sc_commit = 1'b0, vec_issue = 1'b0, vec_commit = 1'b0;
  logic        fetch_hold, sync_done, mem_err;
  logic [31:0] stall_cycles;
  logic        hold_s, done_s, err_s;
  logic [2:0]  stall_s;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  int exp_q[$];
  int exp_stall = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  memsync_stall_unit i_memsync_stall_unit (
    .clk(clk), .rst(rst), .sync_req(sync_req), .sync_kind(sync_kind),
    .sc_issue(sc_issue), .sc_commit(sc_commit), .vec_issue(vec_issue), .vec_commit(vec_commit),
    .fetch_hold(fetch_hold), .sync_done(sync_done), .mem_err(mem_err), .stall_cycles(stall_cycles));

  memsync_stall_unit #(.STALL_W(3)) i_memsync_stall_unit_sat (
    .clk(clk), .rst(rst), .sync_req(sync_req), .sync_kind(sync_kind),
    .sc_issue(sc_issue), .sc_commit(sc_commit), .vec_issue(vec_issue), .vec_commit(vec_commit),
    .fetch_hold(hold_s), .sync_done(done_s), .mem_err(err_s), .stall_cycles(stall_s));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops the expected completion cycle for every sync_done
  always @(negedge clk) begin
    if (!rst && sync_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected sync_done", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R1-kind sync_done cycle", cyc, e);
      end
    end
  end

  // driver: one call is one cycle of stimulus; a request pushes its expected done cycle
  task automatic step(input bit req, input logic [1:0] k, input bit si, input bit sc,
                      input bit vi, input bit vc, input int dly);
    sync_req = req; sync_kind = k;
    sc_issue = si; sc_commit = sc; vec_issue = vi; vec_commit = vc;
    if (req && dly >= 0) exp_q.push_back(cyc + dly);
    @(posedge clk); #1;
    sync_req = 0; sc_issue = 0; sc_commit = 0; vec_issue = 0; vec_commit = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 0, 0, -1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    chk(fetch_hold == 0, "R10 fetch_hold", fetch_hold, 0);
    chk(mem_err == 0, "R10 mem_err", mem_err, 0);
    chk(stall_cycles == 0, "R10 stall_cycles", stall_cycles, 0);
    idle(1);

    // R2: free kinds with vector work in flight
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, -1);
    step(1, 2'b10, 0, 0, 0, 0, 0);
    chk(fetch_hold == 0, "R2 vv no hold", fetch_hold, 0);
    step(1, 2'b11, 0, 0, 0, 0, 0);
    chk(fetch_hold == 0, "R2 elem no hold", fetch_hold, 0);

    // R1/R4/R6: scalar-after-vector, 3 older vector ops
    step(1, 2'b00, 0, 0, 0, 0, 5);
    chk(fetch_hold == 1, "R4 hold rises", fetch_hold, 1);
    idle(1);
    step(1, 2'b10, 0, 0, 0, 1, -1);   // R6 request ignored while pending
    step(0, 0, 0, 0, 0, 1, -1);
    step(0, 0, 0, 0, 0, 1, -1);
    chk(fetch_hold == 1, "R4 hold kept", fetch_hold, 1);
    idle(1);
    chk(fetch_hold == 0, "R4 hold released", fetch_hold, 0);
    exp_stall += 5;
    chk(stall_cycles == exp_stall, "R9 stall count", stall_cycles, exp_stall);
    chk(stall_s == 3'd5, "R9 small count", stall_s, 5);

    // R3: vector-after-scalar with no scalar work, vector work pending
    step(0, 0, 0, 0, 1, 0, -1);
    step(0, 0, 0, 0, 1, 0, -1);
    step(1, 2'b01, 0, 0, 0, 0, 0);
    chk(fetch_hold == 0, "R3 no hold", fetch_hold, 0);
    step(0, 0, 0, 0, 0, 1, -1);
    step(0, 0, 0, 0, 0, 1, -1);

    // R1/R4: vector-after-scalar, 2 scalar ops, commit in request cycle
    step(0, 0, 1, 0, 0, 0, -1);
    step(0, 0, 1, 0, 0, 0, -1);
    step(1, 2'b01, 0, 1, 0, 0, 2);
    step(0, 0, 0, 1, 0, 0, -1);
    idle(1);
    exp_stall += 2;

    // R5: younger vector issues do not extend the wait
    step(0, 0, 0, 0, 1, 0, -1);
    step(1, 2'b00, 0, 0, 1, 0, 3);
    step(0, 0, 0, 0, 1, 0, -1);
    step(0, 0, 0, 0, 0, 1, -1);
    idle(1);
    exp_stall += 3;
    step(0, 0, 0, 0, 0, 1, -1);
    step(0, 0, 0, 0, 0, 1, -1);

    // R7: issue and commit together keep the count at one
    step(0, 0, 1, 0, 0, 0, -1);
    step(0, 0, 1, 1, 0, 0, -1);
    step(1, 2'b01, 0, 0, 0, 0, 2);
    step(0, 0, 0, 1, 0, 0, -1);
    idle(1);
    exp_stall += 2;
    chk(mem_err == 0, "R7 no error", mem_err, 0);

    // R8: underflow sets sticky error, count stays zero
    step(0, 0, 0, 1, 0, 0, -1);
    chk(mem_err == 1, "R8 error set", mem_err, 1);
    idle(2);
    chk(mem_err == 1, "R8 error sticky", mem_err, 1);
    step(1, 2'b01, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, -1);
    step(1, 2'b01, 0, 0, 0, 0, 2);
    step(0, 0, 0, 1, 0, 0, -1);
    idle(1);
    exp_stall += 2;

    // R4: long drain, no timeout
    step(0, 0, 0, 0, 1, 0, -1);
    step(1, 2'b00, 0, 0, 0, 0, 302);
    idle(300);
    chk(fetch_hold == 1, "R4 long hold", fetch_hold, 1);
    step(0, 0, 0, 0, 0, 1, -1);
    idle(2);
    exp_stall += 302;

    // R9: totals and saturation
    chk(stall_cycles == exp_stall, "R9 stall total", stall_cycles, exp_stall);
    chk(stall_s == 3'd7, "R9 saturation", stall_s, 7);
    chk(exp_q.size() == 0, "R4 missing sync_done", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule